// File: doc/BRIEF.md
# Strobe-Driven FIFO with Boundary Flags

This block is a first-in first-out store for 9-bit words, controlled by four active-low lines: a read strobe, a write strobe, a master reset and a retransmit strobe. It runs on one fast sampling clock. Each strobe passes through a synchronizer, and edge detectors find its leading (falling) and trailing (rising) edges. A read or write is claimed on the leading edge and committed on the trailing edge. The read pointer, the write pointer and the occupancy count move only when an access is committed.

The empty and full flags follow handshake rules at the two boundaries. The access that takes the last stored word, or the last free location, raises its flag on its leading edge. Only the trailing edge of a committed access on the other strobe lowers that flag. A strobe that arrives while its flag is raised is claimed by nothing, and it changes nothing in the store.

The data output has a separate enable. The enable models a three-state pin: it is high only while a claimed read is in progress. Retransmit moves the read side back to location zero, so that the stored stream can be read again.

Top module: `strobe_fifo`

## Requirements
- R1: While the master reset is low, and after it is released, empty reads 1, full reads 0, dout_oe reads 0 and dout reads 0.
- R2: A word is stored from din when the write strobe rises, and words are read back in the order they were written.
- R3: The read pointer advances only on the rising edge of an accepted read strobe. A word shown during one read strobe stays on dout until that strobe rises, and the next read shows the following word.
- R4: When one word is stored, the falling edge of the read strobe raises empty while the strobe is still low. Empty stays high after the strobe returns high.
- R5: A read strobe while empty is raised has no effect. dout_oe stays 0, and the next word written is the next word read.
- R6: Empty is lowered by the rising edge of an accepted write strobe. Its falling edge leaves empty unchanged.
- R7: When DEPTH-1 words are stored, the falling edge of the write strobe raises full while the strobe is still low. Full stays high after the strobe rises.
- R8: A write strobe while full is raised is ignored. Its data is discarded, and after the stored DEPTH words have been read the FIFO is empty.
- R9: Full is lowered by the rising edge of an accepted read strobe. Its falling edge leaves full unchanged.
- R10: dout_oe is 1, and dout carries the word, only while an accepted read strobe is low. At all other times dout_oe is 0 and dout is 0.
- R11: On the rising edge of the retransmit strobe, the read pointer returns to location zero and the occupancy becomes the write pointer (the number of words written since reset, when fewer than DEPTH). The write pointer is unchanged. If a read or write strobe was low at any time during the retransmit pulse, the retransmit has no effect.
- R12: Read and write strobes that overlap in time both complete, including when exactly one word was stored at the start.
- R13: A master reset pulse in the middle of operation discards all stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| mrst_n | input | 1 | Master reset, active low, sampled on clk |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rt_n | input | 1 | Retransmit strobe, active low |
| din | input | WIDTH (9) | Write data, held stable until the write strobe's rising edge is seen |
| dout | output | WIDTH (9) | Read data, zero when not enabled |
| dout_oe | output | 1 | Output enable, high during an accepted read |
| empty | output | 1 | Empty flag, active high |
| full | output | 1 | Full flag, active high |

## Verification
The hardest state to reach from the ports is the full boundary. Getting there takes DEPTH-1 complete write strobes before the write that fills the store. That write is then held low so that the flag can be seen before its trailing edge, and an extra write is issued into the full store. A cancelled retransmit is also hard to reach, because it needs a read strobe that overlaps the retransmit pulse. The bench holds a read low, pulses retransmit inside that read, and then checks that the next read continues the sequence instead of replaying it. Overlapping strobes on a single stored word are driven from the same falling clock edge, so that the read claim raises empty while the write is still pending.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  localparam int unsigned WORD_W = 9;
  localparam int unsigned N_LINES = 3;
  localparam int unsigned LN_RD = 0;
  localparam int unsigned LN_WR = 1;
  localparam int unsigned LN_RT = 2;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned LINES  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_n,
  output logic [LINES-1:0] act,
  output logic [LINES-1:0] fall,
  output logic [LINES-1:0] rise
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '1;
        prev <= 1'b1;
      end else begin
        sh   <= {sh[STAGES-2:0], line_n[i]};
        prev <= sh[LAST];
      end
    end

    assign act[i]  = ~sh[LAST];
    assign fall[i] = prev & ~sh[LAST];
    assign rise[i] = ~prev & sh[LAST];
  end
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int unsigned DW = 9,
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
  parameter int unsigned DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_act,
  input  logic                     rd_fall,
  input  logic                     rd_rise,
  input  logic                     wr_act,
  input  logic                     wr_fall,
  input  logic                     wr_rise,
  input  logic                     rt_act,
  input  logic                     rt_fall,
  input  logic                     rt_rise,
  output logic                     we,
  output logic [$clog2(DEPTH)-1:0] waddr,
  output logic [$clog2(DEPTH)-1:0] raddr,
  output logic                     rd_busy,
  output logic                     empty,
  output logic                     full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_d;
  logic          wr_busy, rd_busy_d, wr_busy_d;
  logic          empty_d, full_d;
  logic          rt_block;
  logic          rd_claim, wr_claim, rd_done, wr_done, rt_go;

  // A strobe is claimed on its leading edge only when its flag is clear.
  assign rd_claim = rd_fall && !empty && !rd_busy;
  assign wr_claim = wr_fall && !full && !wr_busy;
  assign rd_done  = rd_rise && rd_busy;
  assign wr_done  = wr_rise && wr_busy;
  assign rt_go    = rt_rise && !rt_block && !rd_act && !wr_act;

  always_comb begin
    rd_busy_d = rd_busy;
    if (rd_claim)     rd_busy_d = 1'b1;
    else if (rd_done) rd_busy_d = 1'b0;

    wr_busy_d = wr_busy;
    if (wr_claim)     wr_busy_d = 1'b1;
    else if (wr_done) wr_busy_d = 1'b0;

    if (rt_go) cnt_d = CW'(wptr) + CW'(wr_done);
    else       cnt_d = cnt + CW'(wr_done) - CW'(rd_done);

    // Words not yet claimed by a read, and locations not yet claimed by a write.
    empty_d = (cnt_d - CW'(rd_busy_d)) == '0;
    full_d  = (FULL_CNT - cnt_d - CW'(wr_busy_d)) == '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      rd_busy  <= 1'b0;
      wr_busy  <= 1'b0;
      empty    <= 1'b1;
      full     <= 1'b0;
      rt_block <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      rd_busy <= rd_busy_d;
      wr_busy <= wr_busy_d;
      empty   <= empty_d;
      full    <= full_d;
      if (wr_done) wptr <= wptr + 1'b1;
      if (rt_go)        rptr <= '0;
      else if (rd_done) rptr <= rptr + 1'b1;
      if (rt_fall)                       rt_block <= rd_act | wr_act;
      else if (rt_act && (rd_act || wr_act)) rt_block <= 1'b1;
    end
  end

  assign we    = wr_done;
  assign waddr = wptr;
  assign raddr = rptr;
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import fifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 512,
  parameter int unsigned WIDTH       = WORD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe,
  output logic             empty,
  output logic             full
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic               rst;
  logic [N_LINES-1:0] line_n, act, fall, rise;
  logic               rd_act, rd_fall, rd_rise;
  logic               wr_act, wr_fall, wr_rise;
  logic               rt_act, rt_fall, rt_rise;
  logic               we, rd_busy;
  logic [AW-1:0]      waddr, raddr;
  logic [WIDTH-1:0]   rdata;

  assign rst = ~mrst_n;

  assign line_n[LN_RD] = rd_n;
  assign line_n[LN_WR] = wr_n;
  assign line_n[LN_RT] = rt_n;

  strobe_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_n(line_n), .act(act), .fall(fall), .rise(rise)
  );

  assign rd_act  = act[LN_RD];
  assign rd_fall = fall[LN_RD];
  assign rd_rise = rise[LN_RD];
  assign wr_act  = act[LN_WR];
  assign wr_fall = fall[LN_WR];
  assign wr_rise = rise[LN_WR];
  assign rt_act  = act[LN_RT];
  assign rt_fall = fall[LN_RT];
  assign rt_rise = rise[LN_RT];

  fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .rd_act(rd_act), .rd_fall(rd_fall), .rd_rise(rd_rise),
    .wr_act(wr_act), .wr_fall(wr_fall), .wr_rise(wr_rise),
    .rt_act(rt_act), .rt_fall(rt_fall), .rt_rise(rt_rise),
    .we(we), .waddr(waddr), .raddr(raddr), .rd_busy(rd_busy),
    .empty(empty), .full(full)
  );

  fifo_ram #(.DW(WIDTH), .AW(AW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(din), .raddr(raddr), .rdata(rdata)
  );

  // Registered output stage; the enable stands in for a three-state driver.
  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= rd_busy;
      dout    <= rd_busy ? rdata : '0;
    end
  end
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk (
  input logic clk,
  input logic rst,
  input logic rd_fall,
  input logic rd_rise,
  input logic wr_fall,
  input logic wr_rise,
  input logic rt_rise,
  input logic empty,
  input logic full,
  input logic dout_oe
);
  // R1: the two flags are never raised together
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  // R4: empty rises only after a read leading edge
  a_r4_empty_on_read_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(empty) |-> ($past(rd_fall) || $past(rst)));

  // R6: empty falls only after a write trailing edge or a retransmit
  a_r6_empty_release_write_rise: assert property (@(posedge clk) disable iff (rst)
    $fell(empty) |-> ($past(wr_rise) || $past(rt_rise)));

  // R7: full rises only after a write leading edge or a retransmit
  a_r7_full_on_write_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> ($past(wr_fall) || $past(rt_rise)));

  // R9: full falls only after a read trailing edge, a retransmit or a reset
  a_r9_full_release_read_rise: assert property (@(posedge clk) disable iff (rst)
    $fell(full) |-> ($past(rd_rise) || $past(rt_rise) || $past(rst)));

  // R10: the output enable follows a read claim two cycles earlier
  a_r10_oe_after_read_claim: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe) |-> $past(rd_fall, 2));
endmodule

bind strobe_fifo strobe_fifo_chk u_chk (
  .clk(clk), .rst(rst),
  .rd_fall(rd_fall), .rd_rise(rd_rise),
  .wr_fall(wr_fall), .wr_rise(wr_rise),
  .rt_rise(rt_rise),
  .empty(empty), .full(full), .dout_oe(dout_oe)
);

// File: tb/sim_strobe_fifo.sv
`timescale 1ns/1ps
module sim_strobe_fifo;
  localparam int unsigned DEPTH = 512;

  logic       clk = 1'b0;
  logic       mrst_n = 1'b0;
  logic       rd_n = 1'b1, wr_n = 1'b1, rt_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       dout_oe, empty, full;
  int         checks = 0;
  int         fails = 0;

  always #4 clk = ~clk;

  strobe_fifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .mrst_n(mrst_n), .rd_n(rd_n), .wr_n(wr_n), .rt_n(rt_n),
    .din(din), .dout(dout), .dout_oe(dout_oe), .empty(empty), .full(full)
  );

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 11) % 512);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    mrst_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; rt_n = 1'b1;
    repeat (4) @(negedge clk);
    mrst_n = 1'b1;
    settle();
  endtask

  task automatic write_word(input logic [8:0] d);
    din = d; wr_n = 1'b0; settle();
    wr_n = 1'b1; settle();
  endtask

  task automatic read_word(input logic [8:0] exp, input string req);
    rd_n = 1'b0; settle();
    chk({req, " oe during read"}, int'(dout_oe), 1);
    chk({req, " data"}, int'(dout), int'(exp));
    rd_n = 1'b1; settle();
  endtask

  task automatic read_get(output logic [8:0] v);
    rd_n = 1'b0; settle();
    v = dout;
    rd_n = 1'b1; settle();
  endtask

  task automatic t_reset();
    @(negedge clk); mrst_n = 1'b0; repeat (3) @(negedge clk);
    chk("R1 empty in reset", int'(empty), 1);
    mrst_n = 1'b1; settle();
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 oe", int'(dout_oe), 0);
    chk("R1 dout", int'(dout), 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 4; i++) write_word(pat(i));
    chk("R2 not empty after writes", int'(empty), 0);
    for (int i = 0; i < 3; i++) read_word(pat(i), "R2 R3 order");
    rd_n = 1'b0; settle();
    chk("R10 oe while read low", int'(dout_oe), 1);
    chk("R3 data held", int'(dout), int'(pat(3)));
    repeat (4) @(negedge clk);
    chk("R3 data still held", int'(dout), int'(pat(3)));
    rd_n = 1'b1; settle();
    chk("R10 oe after read", int'(dout_oe), 0);
    chk("R10 dout zero after read", int'(dout), 0);
    chk("R4 empty after last", int'(empty), 1);
  endtask

  task automatic t_empty_boundary();
    write_word(9'h15a);
    rd_n = 1'b0; settle();
    chk("R4 empty on read fall", int'(empty), 1);
    chk("R4 data of last word", int'(dout), 9'h15a);
    rd_n = 1'b1; settle();
    chk("R4 empty held", int'(empty), 1);
    rd_n = 1'b0; settle();
    chk("R5 oe on empty read", int'(dout_oe), 0);
    rd_n = 1'b1; settle();
    din = 9'h0c3; wr_n = 1'b0; settle();
    chk("R6 empty kept at write fall", int'(empty), 1);
    wr_n = 1'b1; settle();
    chk("R6 empty released at write rise", int'(empty), 0);
    read_word(9'h0c3, "R5 pointer unchanged");
    chk("R5 empty after", int'(empty), 1);
  endtask

  task automatic t_full();
    int bad = 0;
    logic [8:0] v;
    for (int i = 0; i < int'(DEPTH) - 1; i++) write_word(pat(i + 100));
    chk("R7 not full at DEPTH-1", int'(full), 0);
    din = pat(int'(DEPTH) + 99); wr_n = 1'b0; settle();
    chk("R7 full on write fall", int'(full), 1);
    wr_n = 1'b1; settle();
    chk("R7 full held", int'(full), 1);
    write_word(9'h1ff);
    chk("R8 full after ignored write", int'(full), 1);
    rd_n = 1'b0; settle();
    chk("R9 full kept at read fall", int'(full), 1);
    chk("R9 first word", int'(dout), int'(pat(100)));
    rd_n = 1'b1; settle();
    chk("R9 full released at read rise", int'(full), 0);
    for (int i = 1; i < int'(DEPTH); i++) begin
      read_get(v);
      if (v != pat(i + 100)) bad++;
    end
    chk("R8 stored sequence intact", bad, 0);
    chk("R8 empty after DEPTH reads", int'(empty), 1);
  endtask

  task automatic t_retransmit();
    do_reset();
    for (int i = 0; i < 5; i++) write_word(pat(i + 40));
    read_word(pat(40), "R11 before");
    read_word(pat(41), "R11 before");
    rt_n = 1'b0; settle(); rt_n = 1'b1; settle();
    for (int i = 0; i < 5; i++) read_word(pat(i + 40), "R11 replay");
    chk("R11 empty after replay", int'(empty), 1);
    for (int i = 5; i < 8; i++) write_word(pat(i + 40));
    rd_n = 1'b0; settle();
    chk("R11 word at read", int'(dout), int'(pat(45)));
    rt_n = 1'b0; settle(); rt_n = 1'b1; settle();
    rd_n = 1'b1; settle();
    read_word(pat(46), "R11 cancelled retransmit");
    read_word(pat(47), "R11 cancelled retransmit");
  endtask

  task automatic t_simul();
    do_reset();
    write_word(9'h0aa);
    din = 9'h155; rd_n = 1'b0; wr_n = 1'b0; settle();
    chk("R12 empty while both low", int'(empty), 1);
    chk("R12 read data", int'(dout), 9'h0aa);
    rd_n = 1'b1; wr_n = 1'b1; settle();
    chk("R12 empty after both", int'(empty), 0);
    read_word(9'h155, "R12 write completed");
    chk("R12 empty at end", int'(empty), 1);
  endtask

  task automatic t_mreset();
    for (int i = 0; i < 3; i++) write_word(pat(i + 200));
    chk("R13 filled", int'(empty), 0);
    do_reset();
    chk("R13 empty after reset", int'(empty), 1);
    chk("R13 full after reset", int'(full), 0);
    write_word(9'h033);
    read_word(9'h033, "R13 contents discarded");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_empty_boundary();
    t_full();
    t_retransmit();
    t_simul();
    t_mreset();
    summary();
    $finish;
  end
endmodule